// File: doc/BRIEF.md
# Long-Press Reset Controller

This block turns a push-button level into a hard reset request. A short press does nothing, which leaves the button free to serve as an ordinary interrupt source elsewhere. Only a press held without a break for a long setup time, set in half-second steps from 0.5 s to 10 s, raises the reset output. One build-time option lets the reset follow the button until release. The other gives a fixed-length pulse and then waits for the button to be let go.

For production testing, a digital flag from an external overvoltage comparator puts the block into a latched test mode. An initial 42 ms timer runs first and then fires a reset, which serves as proof that test mode was entered. While test mode is active, each press needs only 1/128 of the normal setup time. Test mode ends only at a power-on reset.

All timing counts in fine ticks of 1/128 ms. A free-running prescaler derives these ticks from the clock. Both inputs pass through two-flop synchronizers. The output polarity is a parameter.

Top module: `lpress_rst`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it rises, the block is idle: the reset output is inactive and test mode is cleared.
- R2: In normal mode, reset asserts only after the synchronized button has been held continuously for SETUP_HALF_S x 500 x 128 fine ticks.
- R3: A press released before its setup time ends produces no reset, and the hold count restarts from zero at the next press.
- R4: With FIXED_PULSE = 0, a reset started by a press stays active while the button is held and ends once the release has been synchronized. There is no minimum width.
- R5: With FIXED_PULSE = 1, reset lasts the pulse time whatever the button does. No new reset can start until the button has been released.
- R6: PULSE_SEL chooses the fixed pulse length in fine ticks: 0 = 164 (1.28 ms), 1 = 12800 (100 ms), 2 = 26880 (210 ms), 3 = 46080 (360 ms).
- R7: ACT_HIGH = 1 drives the active reset as 1 and the inactive reset as 0. ACT_HIGH = 0 inverts both levels.
- R8: When the synchronized overvoltage flag is seen outside test mode, test mode latches and any activity in progress is abandoned. A 5376-tick (42 ms) initial timer then runs, and reset asserts when it expires.
- R9: The reset that follows the initial timer lasts the pulse time when FIXED_PULSE = 1. When FIXED_PULSE = 0 it lasts while the overvoltage flag stays set.
- R10: In test mode, the setup time for a press is SETUP_HALF_S x 500 fine ticks, which is 1/128 of the normal setup time.
- R11: Test mode is sticky. Button presses and further overvoltage flags neither clear it nor restart the initial timer. Only `por_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| btn_n | input | 1 | Push-button level, low while pressed (asynchronous) |
| ovr_i | input | 1 | Overvoltage comparator flag, high when detected (asynchronous) |
| rst_o | output | 1 | Reset output, polarity set by ACT_HIGH |

## Verification
Any input change reaches the state register on the third rising edge after it is driven: two synchronizer edges, then the edge that updates the state. The output is decoded directly from that state. A press of L ticks therefore raises reset L+3 edges after the button falls, and a release drops a button-following reset three edges after the button rises. The reference model in the bench carries the same two-stage input delay and counts ticks with integers. Its predicted level is compared with the output half a cycle after every edge, so each result is checked in the cycle it becomes due. Point checks are placed well inside the settled windows: just past the setup time, inside and after the pulse, and after the release has propagated.

// File: rtl/lpress_rst.sv
module lpress_rst #(
  parameter int unsigned FINE_CYC     = 1000,
  parameter int unsigned SETUP_HALF_S = 8,
  parameter int unsigned PULSE_SEL    = 2,
  parameter bit          FIXED_PULSE  = 1'b1,
  parameter bit          ACT_HIGH     = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic btn_n,
  input  logic ovr_i,
  output logic rst_o
);

  function automatic int unsigned pulse_ticks(input int unsigned sel);
    case (sel)
      0:       return 164;
      1:       return 12800;
      2:       return 26880;
      default: return 46080;
    endcase
  endfunction

  localparam int unsigned SETUP_T = SETUP_HALF_S * 500;
  localparam int unsigned SETUP_N = SETUP_T * 128;
  localparam int unsigned INIT_T  = 42 * 128;
  localparam int unsigned PULSE_T = pulse_ticks(PULSE_SEL);
  localparam int unsigned CW      = $clog2(SETUP_N + 1);
  localparam int unsigned PW      = (FINE_CYC > 1) ? $clog2(FINE_CYC) : 1;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_FIRE, S_TINIT, S_TFIRE, S_WREL} st_t;

  logic          b_meta, b_s, o_meta, o_s;
  logic [PW-1:0] pre_q;
  logic          tick;
  st_t           state, st_d;
  logic [CW-1:0] cnt, cnt_d, tgt;
  logic          test_q, test_d;
  logic          last;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      b_meta <= 1'b0;
      b_s    <= 1'b0;
      o_meta <= 1'b0;
      o_s    <= 1'b0;
    end else begin
      b_meta <= ~btn_n;
      b_s    <= b_meta;
      o_meta <= ovr_i;
      o_s    <= o_meta;
    end
  end

  assign tick = (pre_q == PW'(FINE_CYC - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    case (state)
      S_HOLD:  tgt = test_q ? CW'(SETUP_T) : CW'(SETUP_N);
      S_TINIT: tgt = CW'(INIT_T);
      default: tgt = CW'(PULSE_T);
    endcase
  end

  assign last = (cnt == tgt - 1'b1);

  always_comb begin
    st_d   = state;
    cnt_d  = cnt;
    test_d = test_q;
    if (o_s && !test_q) begin
      test_d = 1'b1;
      st_d   = S_TINIT;
      cnt_d  = '0;
    end else begin
      case (state)
        S_IDLE:
          if (b_s) begin
            st_d  = S_HOLD;
            cnt_d = '0;
          end
        S_HOLD:
          if (!b_s) st_d = S_IDLE;
          else if (tick) begin
            if (last) begin
              st_d  = S_FIRE;
              cnt_d = '0;
            end else cnt_d = cnt + 1'b1;
          end
        S_FIRE:
          if (FIXED_PULSE) begin
            if (tick) begin
              if (last) st_d = S_WREL;
              else      cnt_d = cnt + 1'b1;
            end
          end else if (!b_s) st_d = S_IDLE;
        S_TINIT:
          if (tick) begin
            if (last) begin
              st_d  = S_TFIRE;
              cnt_d = '0;
            end else cnt_d = cnt + 1'b1;
          end
        S_TFIRE:
          if (FIXED_PULSE) begin
            if (tick) begin
              if (last) st_d = S_WREL;
              else      cnt_d = cnt + 1'b1;
            end
          end else if (!o_s) st_d = S_IDLE;
        S_WREL:
          if (!b_s) st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      test_q <= 1'b0;
    end else begin
      state  <= st_d;
      cnt    <= cnt_d;
      test_q <= test_d;
    end
  end

  assign rst_o = ((state == S_FIRE) || (state == S_TFIRE)) ? ACT_HIGH : ~ACT_HIGH;

  p_start_idle_r1: assert property (@(posedge clk) disable iff (!por_n)
    !$past(por_n) |-> (state == S_IDLE && !test_q && rst_o == ~ACT_HIGH));

  p_fire_after_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_FIRE && $past(state) != S_FIRE) |-> ($past(state) == S_HOLD && $past(b_s)));

  p_release_aborts_r3: assert property (@(posedge clk) disable iff (!por_n)
    (state == S_HOLD && !b_s && (test_q || !o_s)) |=> state == S_IDLE);

  p_enter_test_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(test_q) |-> (state == S_TINIT && cnt == '0));

  p_sticky_test_r11: assert property (@(posedge clk) disable iff (!por_n)
    test_q |=> test_q);

  generate
    if (FIXED_PULSE) begin : g_fixed
      p_wait_release_r5: assert property (@(posedge clk) disable iff (!por_n)
        (state == S_WREL && b_s && test_q == $past(test_q)) |=> state == S_WREL);
    end else begin : g_follow
      p_follow_button_r4: assert property (@(posedge clk) disable iff (!por_n)
        (state == S_FIRE && !b_s) |=> state != S_FIRE);
    end
  endgenerate

endmodule

// File: tb/lpress_rst_tb.sv
`timescale 1ns/1ps
module lpress_rst_tb;

  localparam int L_N  = 64000;
  localparam int L_T  = 500;
  localparam int INIT = 5376;
  localparam int P    = 164;
  localparam int ID = 0, HO = 1, FI = 2, TI = 3, TF = 4, WR = 5;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic btn_n = 1'b1;
  logic ovr_i = 1'b0;
  logic rst_fx, rst_bt;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpress_rst #(.FINE_CYC(1), .SETUP_HALF_S(1), .PULSE_SEL(0), .FIXED_PULSE(1'b1), .ACT_HIGH(1'b0))
    u_dut (.clk(clk), .por_n(por_n), .btn_n(btn_n), .ovr_i(ovr_i), .rst_o(rst_fx));

  lpress_rst #(.FINE_CYC(1), .SETUP_HALF_S(1), .PULSE_SEL(0), .FIXED_PULSE(1'b0), .ACT_HIGH(1'b1))
    u_dut_btn (.clk(clk), .por_n(por_n), .btn_n(btn_n), .ovr_i(ovr_i), .rst_o(rst_bt));

  // reference model: two-stage input delay, integer state and tick count
  int ms [2];
  int mc [2];
  bit mt [2];
  bit sb1, sb2, so1, so2;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int k = 0; k < 2; k++) begin ms[k] = ID; mc[k] = 0; mt[k] = 0; end
      sb1 = 0; sb2 = 0; so1 = 0; so2 = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit fx;
        int lim;
        fx  = (k == 0);
        lim = mt[k] ? L_T : L_N;
        if (so2 && !mt[k]) begin
          mt[k] = 1; ms[k] = TI; mc[k] = 0;
        end else begin
          case (ms[k])
            ID: if (sb2) begin ms[k] = HO; mc[k] = 0; end
            HO: if (!sb2) ms[k] = ID;
                else if (mc[k] == lim - 1) begin ms[k] = FI; mc[k] = 0; end
                else mc[k]++;
            FI: if (fx) begin if (mc[k] == P - 1) ms[k] = WR; else mc[k]++; end
                else if (!sb2) ms[k] = ID;
            TI: if (mc[k] == INIT - 1) begin ms[k] = TF; mc[k] = 0; end else mc[k]++;
            TF: if (fx) begin if (mc[k] == P - 1) ms[k] = WR; else mc[k]++; end
                else if (!so2) ms[k] = ID;
            default: if (!sb2) ms[k] = ID;
          endcase
        end
      end
      sb2 = sb1; sb1 = ~btn_n;
      so2 = so1; so1 = ovr_i;
    end
  end

  function automatic string tag_of(input int st, input bit t, input bit fx);
    case (st)
      HO: return t ? "R10" : "R2";
      FI: return fx ? "R5" : "R4";
      TI: return "R8";
      TF: return "R9";
      WR: return "R5";
      default: return t ? "R11" : "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison, fire tracking
  int wfx = 0, last_wfx = 0;
  bit any_fire = 0;
  always @(negedge clk) begin
    if (!done) begin
      bit e0, e1;
      e0 = (ms[0] == FI || ms[0] == TF);
      e1 = (ms[1] == FI || ms[1] == TF);
      chk(tag_of(ms[0], mt[0], 1'b1), rst_fx, !e0);
      chk(tag_of(ms[1], mt[1], 1'b0), rst_bt, e1);
      if (rst_fx == 1'b0) wfx++;
      else if (wfx != 0) begin last_wfx = wfx; wfx = 0; end
      if (rst_fx == 1'b0 || rst_bt == 1'b1) any_fire = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL R2 watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    step(5);
    chk("R1 reset fixed inactive", rst_fx, 1);
    chk("R7 active-high idle level", rst_bt, 0);
    por_n = 1'b1;
    step(20);
    any_fire = 0;
    // short press
    btn_n = 1'b0; step(1000); btn_n = 1'b1; step(20);
    chk("R3 short press no reset", any_fire, 0);
    // press just short of setup
    btn_n = 1'b0; step(63000); btn_n = 1'b1; step(20);
    chk("R3 near-setup press no reset", any_fire, 0);
    // long press
    btn_n = 1'b0; step(L_N + 10);
    chk("R2 fixed fires after setup", rst_fx, 0);
    chk("R7 active-high fires", rst_bt, 1);
    step(500);
    chk("R5 fixed pulse ended while held", rst_fx, 1);
    chk("R4 follows held button", rst_bt, 1);
    btn_n = 1'b1; step(10);
    chk("R4 ends after release", rst_bt, 0);
    chk("R6 pulse width 164 ticks", last_wfx, P);
    // enter test mode
    ovr_i = 1'b1; step(INIT + 10);
    chk("R8 init timer fires fixed", rst_fx, 0);
    chk("R8 init timer fires follow", rst_bt, 1);
    step(300);
    chk("R9 fixed test pulse ended", rst_fx, 1);
    chk("R9 follow holds with flag", rst_bt, 1);
    ovr_i = 1'b0; step(10);
    chk("R9 follow drops with flag", rst_bt, 0);
    chk("R6 test pulse width", last_wfx, P);
    step(20);
    any_fire = 0;
    btn_n = 1'b0; step(L_T - 200); btn_n = 1'b1; step(20);
    chk("R10 under short setup no reset", any_fire, 0);
    btn_n = 1'b0; step(L_T + 100);
    chk("R10 short setup fires fixed", rst_fx, 0);
    chk("R10 short setup fires follow", rst_bt, 1);
    btn_n = 1'b1; step(300);
    any_fire = 0;
    // flag again: no restart
    ovr_i = 1'b1; step(6000); ovr_i = 1'b0; step(20);
    chk("R11 second flag no timer", any_fire, 0);
    btn_n = 1'b0; step(L_T + 100);
    chk("R11 still short setup", rst_bt, 1);
    btn_n = 1'b1; step(300);
    // power-on reset clears test mode
    por_n = 1'b0; step(5); por_n = 1'b1; step(20);
    any_fire = 0;
    btn_n = 1'b0; step(L_T + 100);
    chk("R11 reset clears test mode", any_fire, 0);
    chk("R1 normal after reset", rst_bt, 0);
    btn_n = 1'b1; step(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule